// File: doc/BRIEF.md
# Chained Double-Buffer DMA Channel

This block is one DMA channel that moves 32-bit words between a device word stream and memory. Software loads a current buffer (a next pointer and a limit pointer) and can load a second buffer (a start pointer and a stop pointer). It then writes a command word to the control register. The command starts the channel, picks the direction and can arm chaining. The channel walks the next pointer toward the limit one word at a time through a single-outstanding memory request port. A four-word holding FIFO sits between memory and the device stream.

When next reaches limit, one of two things happens. If chaining is armed, the channel loads the second buffer into the current pointers and keeps moving without a gap. If chaining is not armed, it stops. In both cases it raises a completion interrupt and snapshots the pointers so that software can restart the transfer later. An error response on the memory port halts the channel and leaves the pointers frozen at the failing word.

Top module: `dma_chain_chan`

## Requirements
- R1: After reset the control register reads 0, `irq_o` is low, no memory request is raised and the device input is not ready.
- R2: Register word indices are: 0 control, 1 next, 2 limit, 3 start, 4 stop, 5 to 8 saved next, limit, start and stop. Control reads back enable at bit 24, chain-armed at bit 25, direction at bit 26 (1 = device to memory), complete at bit 27 and bus exception at bit 28. Control writes are commands:
  - bit 16 sets enable;
  - bit 17 arms chaining;
  - bit 18 gives the direction, taken only while the channel is disabled with no request in flight;
  - bit 19 clears complete;
  - bit 20 resets;
  - bit 21 flushes the FIFO.
- R3: The reset command clears enable, chain-armed, complete and bus exception together.
- R4: In device-to-memory mode, each accepted stream word is written to memory at the next pointer, and next advances by 4 per word. When next equals limit with chaining not armed, complete sets and enable clears.
- R5: In memory-to-device mode, words are read from next upward and delivered on the output stream in address order.
- R6: When next equals limit with chaining armed, start and stop are copied into next and limit, chain-armed clears, complete sets and enable stays set.
- R7: While enable is set, writes to next and limit are ignored. Writes to start and stop are accepted at any time.
- R8: Next and start writes drop address bits 1:0. Limit and stop writes drop address bits 3:0.
- R9: An error response sets bus exception, clears enable and leaves next at the failing address with no memory write done.
- R10: `irq_o` follows complete and stays high until a clear-complete or reset command.
- R11: The FIFO holds at most 4 words; memory-to-device prefetch stalls when it is full. The flush command empties the FIFO only while the channel is disabled.
- R12: A memory request keeps its address stable until an acknowledge or an error is returned.
- R13: Just before a chain switch or a stop, the current next, limit, start and stop values are copied into the saved registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| mem_req_o | output | 1 | Memory request, held until a response |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Byte address of the word |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with the acknowledge |
| mem_ack_i | input | 1 | Request completed |
| mem_err_i | input | 1 | Request failed |
| dev_in_valid_i | input | 1 | Device word valid (device to memory) |
| dev_in_ready_o | output | 1 | Channel can take a device word |
| dev_in_data_i | input | 32 | Device word |
| dev_out_valid_o | output | 1 | Word for the device valid (memory to device) |
| dev_out_ready_i | input | 1 | Device takes the word |
| dev_out_data_o | output | 32 | Word for the device |
| irq_o | output | 1 | Completion interrupt |

## Verification
The pointers show the internal state most directly. A wrong step size or a missed chain load puts words at the wrong memory addresses, which the bench reads back once the buffer finishes. The same fault also leaves next, limit or the saved copies reading back with the wrong value within a cycle of the event. A bad enable, chain or complete bit shows in the control readback and on `irq_o` at the first clock edge after next meets limit. A FIFO count error shows either as a missing or duplicated word on the output stream, or as `dev_out_valid_o` staying high after a flush.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  localparam int unsigned AW = 32;
  localparam int unsigned DW = 32;
  localparam int unsigned BEG_LSB = 2;  // buffer start: word aligned
  localparam int unsigned END_LSB = 4;  // buffer end: 16-byte aligned

  localparam int ST_EN   = 24;
  localparam int ST_SUP  = 25;
  localparam int ST_DIR  = 26;
  localparam int ST_CMP  = 27;
  localparam int ST_BEXC = 28;

  localparam int CMD_EN   = 16;
  localparam int CMD_SUP  = 17;
  localparam int CMD_DIR  = 18;
  localparam int CMD_CLRC = 19;
  localparam int CMD_RST  = 20;
  localparam int CMD_INIT = 21;

  typedef enum logic [3:0] {
    REG_CTRL     = 4'd0,
    REG_NEXT     = 4'd1,
    REG_LIMIT    = 4'd2,
    REG_START    = 4'd3,
    REG_STOP     = 4'd4,
    REG_SV_NEXT  = 4'd5,
    REG_SV_LIMIT = 4'd6,
    REG_SV_START = 4'd7,
    REG_SV_STOP  = 4'd8
  } reg_sel_e;

  typedef struct packed {
    logic [AW-1:0] nxt;
    logic [AW-1:0] lim;
    logic [AW-1:0] strt;
    logic [AW-1:0] stp;
  } ptr_set_t;
endpackage

// File: rtl/dma_hold_fifo.sv
module dma_hold_fifo #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic          full_o,
  output logic          empty_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [DW-1:0] store_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == FULL);
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = store_q[rp_q];

  always_ff @(posedge clk_i) begin
    if (do_push) store_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == LAST) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == LAST) ? '0 : rp_q + 1'b1;
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  // R11
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  // R11
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/dma_ptr_bank.sv
module dma_ptr_bank
  import dma_chain_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [3:0]    wr_sel_i,
  input  logic [AW-1:0] wr_data_i,
  input  logic          lock_i,
  input  logic          step_i,
  input  logic          chain_i,
  input  logic          save_i,
  output ptr_set_t      cur_o,
  output ptr_set_t      sav_o
);
  localparam logic [AW-1:0] STEP = AW'(DW / 8);

  ptr_set_t cur_q, sav_q;
  logic [AW-1:0] beg_al, end_al;

  assign beg_al = {wr_data_i[AW-1:BEG_LSB], {BEG_LSB{1'b0}}};
  assign end_al = {wr_data_i[AW-1:END_LSB], {END_LSB{1'b0}}};
  assign cur_o  = cur_q;
  assign sav_o  = sav_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0;
      sav_q <= '0;
    end else begin
      if (save_i) sav_q <= cur_q;
      if (chain_i) begin
        cur_q.nxt <= cur_q.strt;
        cur_q.lim <= cur_q.stp;
      end else if (step_i) begin
        cur_q.nxt <= cur_q.nxt + STEP;
      end else if (wr_en_i && !lock_i) begin
        if (wr_sel_i == REG_NEXT)  cur_q.nxt <= beg_al;
        if (wr_sel_i == REG_LIMIT) cur_q.lim <= end_al;
      end
      if (wr_en_i && wr_sel_i == REG_START) cur_q.strt <= beg_al;
      if (wr_en_i && wr_sel_i == REG_STOP)  cur_q.stp  <= end_al;
    end
  end
endmodule

// File: rtl/dma_chain_chan.sv
module dma_chain_chan
  import dma_chain_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [3:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_ack_i,
  input  logic          mem_err_i,
  input  logic          dev_in_valid_i,
  output logic          dev_in_ready_o,
  input  logic [DW-1:0] dev_in_data_i,
  output logic          dev_out_valid_o,
  input  logic          dev_out_ready_i,
  output logic [DW-1:0] dev_out_data_o,
  output logic          irq_o
);
  localparam logic [AW-1:0] STEP = AW'(DW / 8);

  logic en_q, sup_q, dir_q, cmp_q, bexc_q, req_q;
  ptr_set_t cur, sav;
  logic fifo_full, fifo_empty, fifo_push, fifo_pop, fifo_flush;
  logic [DW-1:0] fifo_rdata, fifo_wdata;
  logic ctrl_we, at_end, do_chain, do_stop, step, bus_err, bus_done, launch;
  logic [31:0] status;

  assign ctrl_we  = reg_we_i && (reg_addr_i == REG_CTRL);
  assign at_end   = en_q && !req_q && (cur.nxt == cur.lim);
  assign do_chain = at_end && sup_q;
  assign do_stop  = at_end && !sup_q;
  assign bus_done = req_q && (mem_ack_i || mem_err_i);
  assign step     = req_q && mem_ack_i && !mem_err_i;
  assign bus_err  = req_q && mem_err_i;
  assign launch   = en_q && !req_q && (cur.nxt != cur.lim)
                    && (dir_q ? !fifo_empty : !fifo_full);

  // device->memory: stream fills FIFO, memory writes drain it
  // memory->device: memory reads fill FIFO, stream drains it
  assign dev_in_ready_o  = en_q && dir_q && !fifo_full;
  assign dev_out_valid_o = !dir_q && !fifo_empty;
  assign dev_out_data_o  = fifo_rdata;
  assign fifo_wdata = dir_q ? dev_in_data_i : mem_rdata_i;
  assign fifo_push  = dir_q ? (dev_in_valid_i && dev_in_ready_o) : step;
  assign fifo_pop   = dir_q ? step : (dev_out_valid_o && dev_out_ready_i);
  assign fifo_flush = ctrl_we && reg_wdata_i[CMD_INIT] && !en_q;

  assign mem_req_o   = req_q;
  assign mem_we_o    = dir_q;
  assign mem_addr_o  = cur.nxt;
  assign mem_wdata_o = fifo_rdata;
  assign irq_o       = cmp_q;

  dma_hold_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .flush_i (fifo_flush),
    .push_i  (fifo_push),
    .wdata_i (fifo_wdata),
    .pop_i   (fifo_pop),
    .rdata_o (fifo_rdata),
    .full_o  (fifo_full),
    .empty_o (fifo_empty)
  );

  dma_ptr_bank u_ptr (
    .clk_i, .rst_ni,
    .wr_en_i   (reg_we_i),
    .wr_sel_i  (reg_addr_i),
    .wr_data_i (reg_wdata_i[AW-1:0]),
    .lock_i    (en_q || req_q),
    .step_i    (step),
    .chain_i   (do_chain),
    .save_i    (at_end),
    .cur_o     (cur),
    .sav_o     (sav)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0; sup_q <= 1'b0; dir_q <= 1'b0;
      cmp_q <= 1'b0; bexc_q <= 1'b0; req_q <= 1'b0;
    end else begin
      if (bus_done)    req_q <= 1'b0;
      else if (launch) req_q <= 1'b1;
      if (do_stop || bus_err) en_q <= 1'b0;
      if (do_chain) sup_q <= 1'b0;
      if (ctrl_we) begin
        if (reg_wdata_i[CMD_RST]) begin
          en_q <= 1'b0; sup_q <= 1'b0; cmp_q <= 1'b0; bexc_q <= 1'b0;
        end
        if (reg_wdata_i[CMD_CLRC]) cmp_q <= 1'b0;
        if (reg_wdata_i[CMD_EN])   en_q  <= 1'b1;
        if (reg_wdata_i[CMD_SUP])  sup_q <= 1'b1;
        if (!en_q && !req_q)       dir_q <= reg_wdata_i[CMD_DIR];
      end
      if (at_end)  cmp_q  <= 1'b1;  // event wins over clear
      if (bus_err) bexc_q <= 1'b1;
    end
  end

  always_comb begin
    status = '0;
    status[ST_EN]   = en_q;
    status[ST_SUP]  = sup_q;
    status[ST_DIR]  = dir_q;
    status[ST_CMP]  = cmp_q;
    status[ST_BEXC] = bexc_q;
    case (reg_addr_i)
      REG_CTRL:     reg_rdata_o = status;
      REG_NEXT:     reg_rdata_o = cur.nxt;
      REG_LIMIT:    reg_rdata_o = cur.lim;
      REG_START:    reg_rdata_o = cur.strt;
      REG_STOP:     reg_rdata_o = cur.stp;
      REG_SV_NEXT:  reg_rdata_o = sav.nxt;
      REG_SV_LIMIT: reg_rdata_o = sav.lim;
      REG_SV_START: reg_rdata_o = sav.strt;
      REG_SV_STOP:  reg_rdata_o = sav.stp;
      default:      reg_rdata_o = '0;
    endcase
  end

  // R4
  step_by_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i && !mem_err_i) |=> mem_addr_o == $past(mem_addr_o) + STEP);
  // R4
  stop_at_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_end && !sup_q && !ctrl_we) |=> !en_q && irq_o);
  // R6
  chain_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_end && sup_q && !ctrl_we) |=> en_q && !sup_q && irq_o && cur.nxt == $past(cur.strt)
                                      && cur.lim == $past(cur.stp));
  // R7
  ptr_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && !req_q && cur.nxt != cur.lim) |=> $stable(cur.nxt) && $stable(cur.lim));
  // R9
  bus_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_err_i && !reg_we_i) |=> !en_q && bexc_q && $stable(mem_addr_o) && !mem_req_o);
  // R10
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !ctrl_we) |=> irq_o);
  // R12
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i && !mem_err_i) |=> mem_req_o && $stable(mem_addr_o));
  // R13
  save_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> sav.lim == $past(cur.lim) && sav.stp == $past(cur.stp));
endmodule

// File: tb/tb_dma_chain_chan.sv
module tb_dma_chain_chan;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [3:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic        mem_ack_i = 1'b0, mem_err_i = 1'b0;
  logic        dev_in_valid_i = 1'b0, dev_in_ready_o;
  logic [31:0] dev_in_data_i = '0;
  logic        dev_out_valid_o, dev_out_ready_i = 1'b0;
  logic [31:0] dev_out_data_o;
  logic        irq_o;

  localparam logic [31:0] C_EN = 32'h1 << 16, C_SUP = 32'h1 << 17, C_DIR = 32'h1 << 18,
                          C_CLRC = 32'h1 << 19, C_RST = 32'h1 << 20, C_INIT = 32'h1 << 21;
  localparam logic [31:0] S_EN = 32'h1 << 24, S_SUP = 32'h1 << 25, S_DIR = 32'h1 << 26,
                          S_CMP = 32'h1 << 27, S_BEXC = 32'h1 << 28;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  dma_chain_chan dut (.*);

  always #2 clk_i = ~clk_i;

  // memory model with optional wait states and error injection
  logic [31:0] mem [64];
  int ws = 0, wait_cnt = 0, hold_viol = 0;
  bit pend = 1'b0, err_arm = 1'b0;
  logic [31:0] pend_addr = '0, err_addr = '0;
  assign mem_rdata_i = mem[mem_addr_o[7:2]];

  always @(negedge clk_i) begin
    mem_ack_i <= 1'b0;
    mem_err_i <= 1'b0;
    if (mem_req_o && !mem_ack_i && !mem_err_i) begin
      if (pend && mem_addr_o != pend_addr) hold_viol++;
      if (wait_cnt < ws) begin
        wait_cnt++; pend = 1'b1; pend_addr = mem_addr_o;
      end else begin
        wait_cnt = 0; pend = 1'b0;
        if (err_arm && mem_addr_o == err_addr) mem_err_i <= 1'b1;
        else begin
          mem_ack_i <= 1'b1;
          if (mem_we_o) mem[mem_addr_o[7:2]] <= mem_wdata_o;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic send_words(input int n, input logic [15:0] tag);
    for (int i = 0; i < n; i++) begin
      bit ok;
      int guard;
      ok = 1'b0; guard = 0;
      dev_in_valid_i = 1'b1;
      dev_in_data_i = {tag, 16'(i)};
      while (!ok && guard < 500) begin
        ok = dev_in_ready_o;
        @(negedge clk_i);
        guard++;
      end
    end
    dev_in_valid_i = 1'b0;
  endtask

  task automatic wait_irq();
    int guard;
    guard = 0;
    while (!irq_o && guard < 1000) begin
      @(negedge clk_i);
      guard++;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R1 act=%h exp=%h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    for (int i = 0; i < 64; i++) mem[i] = 32'hEE00_0000 | 32'(i);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    rd(4'd0, v); chk("R1 ctrl", v, 32'h0);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
    chk("R1 req", {31'b0, mem_req_o}, 32'h0);
    chk("R1 ready", {31'b0, dev_in_ready_o}, 32'h0);

    // R8 alignment on write
    wr(4'd1, 32'h47); wr(4'd2, 32'h5F); wr(4'd3, 32'h13); wr(4'd4, 32'h2B);
    rd(4'd1, v); chk("R8 next", v, 32'h44);
    rd(4'd2, v); chk("R8 limit", v, 32'h50);
    rd(4'd3, v); chk("R8 start", v, 32'h10);
    rd(4'd4, v); chk("R8 stop", v, 32'h20);

    // R4 sweep: device->memory over start offsets and two limits
    for (int k = 0; k < 4; k++) begin
      for (int l = 0; l < 2; l++) begin
        logic [31:0] nx, lm;
        int n;
        nx = 32'h40 + 32'(4 * k);
        lm = (l == 0) ? 32'h50 : 32'h60;
        n = int'((lm - nx) >> 2);
        for (int i = 16; i < 28; i++) mem[i] = 32'hEE00_0000 | 32'(i);
        wr(4'd0, C_RST);
        wr(4'd1, nx); wr(4'd2, lm);
        wr(4'd0, C_EN | C_DIR);
        send_words(n, 16'(16'hA000 + 16'(k * 2 + l)));
        wait_irq();
        repeat (2) @(negedge clk_i);
        for (int i = 16; i < 28; i++) begin
          logic [31:0] ex;
          if (i >= int'(nx >> 2) && i < int'(lm >> 2))
            ex = {16'(16'hA000 + 16'(k * 2 + l)), 16'(i - int'(nx >> 2))};
          else
            ex = 32'hEE00_0000 | 32'(i);
          chk("R4 mem word", mem[i], ex);
        end
        rd(4'd0, v); chk("R4 R2 stopped status", v, S_CMP | S_DIR);
        rd(4'd1, v); chk("R4 next at limit", v, lm);
        rd(4'd5, v); chk("R13 saved next", v, lm);
        rd(4'd6, v); chk("R13 saved limit", v, lm);
      end
    end

    // R10 interrupt holds until cleared
    repeat (5) @(negedge clk_i);
    chk("R10 irq held", {31'b0, irq_o}, 32'h1);
    wr(4'd0, C_CLRC);
    chk("R10 irq cleared", {31'b0, irq_o}, 32'h0);

    // R3 reset command clears all flags
    wr(4'd0, C_SUP);
    rd(4'd0, v); chk("R2 sup armed", v, S_SUP);
    wr(4'd0, C_RST);
    rd(4'd0, v); chk("R3 reset cmd", v, 32'h0);

    // R6 chaining with wait states on memory
    ws = 2;
    wr(4'd1, 32'h80); wr(4'd2, 32'h90);
    wr(4'd3, 32'hA0); wr(4'd4, 32'hB0);
    wr(4'd0, C_EN | C_SUP | C_DIR);
    rd(4'd0, v); chk("R2 running status", v, S_EN | S_SUP | S_DIR);
    send_words(4, 16'hC100);
    wait_irq();
    repeat (4) @(negedge clk_i);
    rd(4'd0, v); chk("R6 chained status", v, S_EN | S_CMP | S_DIR);
    rd(4'd1, v); chk("R6 next loaded", v, 32'hA0);
    rd(4'd2, v); chk("R6 limit loaded", v, 32'hB0);
    rd(4'd5, v); chk("R13 saved next at chain", v, 32'h90);
    rd(4'd7, v); chk("R13 saved start at chain", v, 32'hA0);
    // R7 next/limit locked while enabled, start/stop open
    wr(4'd1, 32'h10); wr(4'd2, 32'h20);
    rd(4'd1, v); chk("R7 next locked", v, 32'hA0);
    rd(4'd2, v); chk("R7 limit locked", v, 32'hB0);
    wr(4'd3, 32'hC4);
    rd(4'd3, v); chk("R7 start open", v, 32'hC4);
    wr(4'd0, C_CLRC);
    chk("R10 irq cleared mid-chain", {31'b0, irq_o}, 32'h0);
    send_words(4, 16'hC200);
    wait_irq();
    repeat (2) @(negedge clk_i);
    for (int i = 0; i < 4; i++) begin
      chk("R6 first buffer", mem[32 + i], {16'hC100, 16'(i)});
      chk("R6 second buffer", mem[40 + i], {16'hC200, 16'(i)});
    end
    rd(4'd0, v); chk("R6 final stop", v, S_CMP | S_DIR);
    rd(4'd7, v); chk("R13 saved start at stop", v, 32'hC4);
    rd(4'd8, v); chk("R13 saved stop at stop", v, 32'hB0);
    chk("R12 address held", 32'(hold_viol), 32'h0);
    ws = 0;

    // R5 memory->device
    for (int i = 0; i < 8; i++) mem[i] = 32'h5000 + 32'(i);
    wr(4'd0, C_RST);
    wr(4'd1, 32'h0); wr(4'd2, 32'h20);
    dev_out_ready_i = 1'b1;
    wr(4'd0, C_EN);
    begin
      int got, guard;
      got = 0; guard = 0;
      while (got < 8 && guard < 500) begin
        @(negedge clk_i);
        if (dev_out_valid_o) begin
          chk("R5 stream word", dev_out_data_o, 32'h5000 + 32'(got));
          got++;
        end
        guard++;
      end
      chk("R5 word count", 32'(got), 32'd8);
    end
    wait_irq();
    repeat (3) @(negedge clk_i);
    rd(4'd0, v); chk("R5 stopped status", v, S_CMP);
    chk("R5 stream drained", {31'b0, dev_out_valid_o}, 32'h0);

    // R11 prefetch limit and flush
    dev_out_ready_i = 1'b0;
    wr(4'd0, C_RST);
    wr(4'd1, 32'h0); wr(4'd2, 32'h20);
    wr(4'd0, C_EN);
    repeat (30) @(negedge clk_i);
    rd(4'd1, v); chk("R11 prefetch stops at 4 words", v, 32'h10);
    chk("R11 no request when full", {31'b0, mem_req_o}, 32'h0);
    wr(4'd0, C_INIT);
    chk("R11 flush ignored when enabled", {31'b0, dev_out_valid_o}, 32'h1);
    chk("R11 head word", dev_out_data_o, 32'h5000);
    wr(4'd0, C_RST);
    rd(4'd0, v); chk("R3 reset mid-run", v, 32'h0);
    chk("R11 data kept before flush", {31'b0, dev_out_valid_o}, 32'h1);
    wr(4'd0, C_INIT);
    chk("R11 flushed", {31'b0, dev_out_valid_o}, 32'h0);

    // R9 bus error
    err_arm = 1'b1; err_addr = 32'hC8;
    wr(4'd0, C_RST);
    wr(4'd1, 32'hC0); wr(4'd2, 32'hD0);
    wr(4'd0, C_EN | C_DIR);
    send_words(3, 16'hE000);
    repeat (20) @(negedge clk_i);
    rd(4'd0, v); chk("R9 status", v, S_BEXC | S_DIR);
    chk("R9 no irq", {31'b0, irq_o}, 32'h0);
    rd(4'd1, v); chk("R9 next frozen", v, 32'hC8);
    chk("R9 word before", mem[49], {16'hE000, 16'd1});
    chk("R9 failing word untouched", mem[50], 32'hEE00_0000 | 32'd50);
    chk("R9 request dropped", {31'b0, mem_req_o}, 32'h0);
    wr(4'd0, C_RST);
    rd(4'd0, v); chk("R3 clears bus exception", v, 32'h0);
    err_arm = 1'b0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule